// File: doc/BRIEF.md
# Bit-serial adder with parallel operand load

The block adds two unsigned WIDTH-bit operands one bit per clock, least significant bit first. A parallel load copies both operands into right-shifting registers. A start request then runs the operands bit by bit through a carry-tracking state machine, and a third shift register collects the sum bits, filling from the top. When the last sum bit has been captured, a one-cycle done pulse marks the sum and the final carry as valid. Both stay valid until the next load or start.

The parameter MOORE picks the form of the state machine. With MOORE=0 it is the two-state form: one carry flip-flop, and each sum bit is formed combinationally from a, b and the stored carry. With MOORE=1 it is the four-state form. Two flip-flops hold the carry and the current sum bit, so each sum bit leaves one clock after the operand bits that produce it. The sum register then shifts one cycle later, and done also comes one cycle later.

Top module: `serial_adder_sr`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), done is 0, sum is 0 and carry_out is 0.
- R2: A load (load high at an edge) copies a_in and b_in into the operand registers. It clears sum, carry_out and the state machine to the carry-0 state, and it aborts any run in progress, so no done pulse follows. Load has priority over start.
- R3: A start (start high at an edge with load low) while idle begins a run and clears the carry state. A start during a run has no effect on its timing or result. A start without a new load adds zero operands, because a run shifts the operands out.
- R4: With MOORE=0, done is high in the cycle after the WIDTH-th edge that follows the start edge. At that point sum equals (A+B) mod 2^WIDTH and carry_out equals bit WIDTH of A+B.
- R5: With MOORE=1, the sum bit is registered and done is high one cycle later than in R4: after the (WIDTH+1)-th edge that follows the start edge. sum and carry_out have the same values as in R4.
- R6: done is high for exactly one cycle per completed run. While no run is active and no load or start arrives, sum and carry_out hold.
- R7: The carry state moves from 0 to 1 on a=b=1 and from 1 to 0 on a=b=0, and is otherwise unchanged. The sum bit is a XOR b XOR carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Parallel load of both operands |
| start | input | 1 | Begin a serial addition |
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B |
| sum | output | WIDTH | Collected sum bits |
| carry_out | output | 1 | Carry state; final carry after done |
| done | output | 1 | One-cycle pulse: sum and carry_out are complete |

## Verification
The result is due WIDTH edges after the start edge in the two-state form and WIDTH+1 edges after it in the four-state form. The done pulse, the sum and the carry are all visible in the cycle after that edge. The bench runs both forms side by side from the same stimulus. A countdown per form is loaded with the due latency at an accepted start and decremented at every later edge, and it predicts done in every cycle. Sum and carry are compared in every cycle where no run is in flight, so the reset values, the values after a load, the held results and the effect of an aborted run are all checked at the ports.

// File: rtl/serial_adder_sr.sv
module serial_adder_sr #(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             start,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             done
);
  localparam int LAT  = MOORE ? 1 : 0;
  localparam int LAST = WIDTH - 1 + LAT;
  localparam int CW   = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] a_q, b_q, s_q;
  logic [CW-1:0]    cnt;
  logic             running, done_q, carry_q, sbit, fsm_en, cap_en;

  wire start_go = start && !load && !running;
  wire a_bit    = a_q[0];
  wire b_bit    = b_q[0];
  wire fa_sum   = a_bit ^ b_bit ^ carry_q;
  wire fa_co    = (a_bit & b_bit) | (a_bit & carry_q) | (b_bit & carry_q);

  generate
    if (MOORE) begin : g_moore
      logic y1;
      always_ff @(posedge clk) begin
        if (rst || load || start_go) y1 <= 1'b0;
        else if (fsm_en)             y1 <= fa_sum;
      end
      assign sbit   = y1;
      assign fsm_en = running && (cnt != CW'(WIDTH));
      assign cap_en = running && (cnt != '0);
    end else begin : g_mealy
      assign sbit   = fa_sum;
      assign fsm_en = running;
      assign cap_en = running;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || load || start_go) carry_q <= 1'b0;
    else if (fsm_en)             carry_q <= fa_co;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= a_in;
      b_q <= b_in;
    end else if (fsm_en) begin
      a_q <= a_q >> 1;
      b_q <= b_q >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load) s_q <= '0;
    else if (cap_en) s_q <= {sbit, s_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        running <= 1'b0;
        cnt     <= '0;
      end else if (running) begin
        if (cnt == CW'(LAST)) begin
          running <= 1'b0;
          done_q  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (start) begin
        running <= 1'b1;
        cnt     <= '0;
      end
    end
  end

  assign sum       = s_q;
  assign carry_out = carry_q;
  assign done      = done_q;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!running && !load && !start) |=> ($stable(sum) && $stable(carry_out)));
  p_load_clear_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (sum == '0 && !carry_out && !done && !running));
  p_start_runs_r3: assert property (@(posedge clk) disable iff (rst)
    start_go |=> (running && !carry_out));
  p_carry_step_r7: assert property (@(posedge clk) disable iff (rst)
    (fsm_en && !load && a_bit && b_bit) |=> carry_out);
  p_carry_kill_r7: assert property (@(posedge clk) disable iff (rst)
    (fsm_en && !load && !a_bit && !b_bit) |=> !carry_out);
  p_done_after_run_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(running));
endmodule

// File: tb/tb_serial_adder_sr.sv
module tb_serial_adder_sr;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst, load, start;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] sum_o [2];
  logic car_o [2], done_o [2];

  always #2 clk = ~clk;

  serial_adder_sr #(.WIDTH(W), .MOORE(1'b0)) dut (
    .clk(clk), .rst(rst), .load(load), .start(start), .a_in(a_in), .b_in(b_in),
    .sum(sum_o[0]), .carry_out(car_o[0]), .done(done_o[0]));
  serial_adder_sr #(.WIDTH(W), .MOORE(1'b1)) dut_moore (
    .clk(clk), .rst(rst), .load(load), .start(start), .a_in(a_in), .b_in(b_in),
    .sum(sum_o[1]), .carry_out(car_o[1]), .done(done_o[1]));

  int vectors = 0, errors = 0, ndone = 0;
  bit finished = 0;
  int cd [2];
  bit dexp [2];
  bit ecar [2];
  logic [W-1:0] esum [2], oa [2], ob [2], ra [2], rb [2];

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      logic [W:0] tot;
      dexp[k] = 0;
      if (rst) begin
        cd[k] = 0; esum[k] = '0; ecar[k] = 0; oa[k] = '0; ob[k] = '0;
      end else if (load) begin
        cd[k] = 0; esum[k] = '0; ecar[k] = 0; oa[k] = a_in; ob[k] = b_in;
      end else if (cd[k] > 0) begin
        cd[k]--;
        if (cd[k] == 0) begin
          tot = {1'b0, ra[k]} + {1'b0, rb[k]};
          dexp[k] = 1; esum[k] = tot[W-1:0]; ecar[k] = tot[W];
        end
      end else if (start) begin
        cd[k] = W + k; ra[k] = oa[k]; rb[k] = ob[k]; oa[k] = '0; ob[k] = '0;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      for (int k = 0; k < 2; k++) begin
        vectors++;
        if (done_o[k] !== dexp[k]) begin
          errors++;
          $display("FAIL %s form %0d: done=%b expected %b", k ? "R5" : "R4", k, done_o[k], dexp[k]);
        end
        if (dexp[k]) ndone++;
        if (cd[k] == 0) begin
          vectors++;
          if (sum_o[k] !== esum[k] || car_o[k] !== ecar[k]) begin
            errors++;
            $display("FAIL R2/R6 form %0d: sum=%h carry=%b expected sum=%h carry=%b",
                     k, sum_o[k], car_o[k], esum[k], ecar[k]);
          end
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_add(logic [W-1:0] a, logic [W-1:0] b);
    load = 1; a_in = a; b_in = b; tick(1);
    load = 0; tick(1);
    start = 1; tick(1);
    start = 0; tick(W + 3);
  endtask

  initial begin
    rst = 1; load = 0; start = 0; a_in = '0; b_in = '0;
    tick(3);
    rst = 0; tick(2);                       // R1 reset state
    run_add(8'h00, 8'h00);                  // R4 R5
    run_add(8'hFF, 8'hFF);                  // R7 long carry
    run_add(8'hFF, 8'h01);                  // full ripple, carry out
    run_add(8'hA5, 8'h5A);
    run_add(8'h80, 8'h80);                  // carry only from top bit
    run_add(8'h3C, 8'hC3);
    for (int i = 0; i < 6; i++) run_add(W'($urandom), W'($urandom));
    // R3: start during run ignored
    load = 1; a_in = 8'h77; b_in = 8'h99; tick(1);
    load = 0; start = 1; tick(1);
    start = 0; tick(3);
    start = 1; tick(1);
    start = 0; tick(W + 3);
    // R3: restart without load adds zeros
    start = 1; tick(1);
    start = 0; tick(W + 3);
    // R2: load aborts a run
    load = 1; a_in = 8'h12; b_in = 8'hF0; tick(1);
    load = 0; start = 1; tick(1);
    start = 0; tick(4);
    load = 1; a_in = 8'h0F; b_in = 8'hF1; tick(1);
    load = 0; tick(W + 3);                  // no done expected
    start = 1; load = 1; tick(1);           // R2 load beats start
    start = 0; load = 0; tick(W + 3);
    run_add(8'h01, 8'hFF);
    // R1: reset in mid run
    load = 1; tick(1); load = 0; start = 1; tick(1); start = 0; tick(3);
    rst = 1; tick(1); rst = 0; tick(W + 3);
    if (ndone < 30) begin
      errors++;
      $display("FAIL R6: %0d done pulses seen, expected at least 30", ndone);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule